// File: doc/BRIEF.md
# Clock Tree Frequency Calculator

This block works out, in hertz, the frequencies along one branch of a clock tree. It starts from a fixed 24 MHz reference and a system PLL with two selectable multipliers. From there it derives two fractional-divider taps, a peripheral root picked from four candidates, and three bus clocks that each divide the one above. All inputs are raw configuration register words. The bit position of each field inside its word is a parameter. No clock is generated or gated here; the block only produces numbers for software-visible models and for consumers such as a timer that need to know their tick rate.

A one-cycle start strobe samples every field at once. The block then runs five divisions in sequence on one shared restoring divider, which produces one quotient bit per cycle. When the last stage is stored, a valid flag rises. The results stay on the outputs until the next accepted start. A three-bit clock-select input picks which value is reported on a single consumer output. The choices are nothing, the IPG clock, the high-frequency peripheral clock, or a 32768 Hz constant.

Top module: `clk_freq_calc`

## Requirements
- R1: The PLL value is 528000000 Hz when bit 0 of the PLL word is 1 and 480000000 Hz when it is 0; no other bit of that word matters.
- R2: Each fractional tap equals floor(PLL * 18 / frac), where tap 0 uses frac word bits [5:0] and tap 2 uses frac word bits [21:16].
- R3: A fraction field of zero makes that tap 0 instead of dividing by zero.
- R4: Root word bits [19:18] select the peripheral root: 0 the PLL, 1 tap 2, 2 tap 0, 3 floor(tap 2 / 2).
- R5: AHB = floor(root / (1 + bus word bits [12:10])), IPG = floor(AHB / (1 + bus word bits [9:8])), per-clock = floor(IPG / (1 + per word bits [5:0])).
- R6: While valid is high, the select output gives 0 for code 0, IPG for code 1, per-clock for code 2, 32768 for code 3, and 0 for codes 4 to 7; while valid is low it gives 0.
- R7: An accepted start drops valid at the next edge; valid rises no later than 331 cycles after that edge (64-bit divider) and then stays high, with all results held, until the next accepted start.
- R8: A start while busy is ignored, and configuration changes after an accepted start have no effect on that computation.
- R9: After reset, valid and busy are low and every frequency output reads 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start_i | input | 1 | Start strobe, accepted only when idle |
| pll_cfg_i | input | 32 | PLL configuration word (multiplier select) |
| frac_cfg_i | input | 32 | Fractional divider word (both fraction fields) |
| bus_div_cfg_i | input | 32 | Bus divider word (AHB and IPG divide fields) |
| root_cfg_i | input | 32 | Root multiplexer word (root select field) |
| per_cfg_i | input | 32 | Per-clock divider word |
| clk_sel_i | input | 3 | Consumer clock select code |
| busy_o | output | 1 | Computation in progress |
| valid_o | output | 1 | Results complete and held |
| pll_hz_o | output | 64 | PLL frequency |
| pfd0_hz_o | output | 64 | Fractional tap 0 frequency |
| pfd2_hz_o | output | 64 | Fractional tap 2 frequency |
| root_hz_o | output | 64 | Peripheral root frequency |
| ahb_hz_o | output | 64 | AHB frequency |
| ipg_hz_o | output | 64 | IPG frequency |
| per_hz_o | output | 64 | Per-clock frequency |
| sel_hz_o | output | 64 | Frequency of the selected consumer clock |

## Verification
The chain is driven with configurations that cover both PLL multipliers and all four root selections, including the halved tap. Each configuration is distinct, so a swapped select code or a misplaced field yields a different number at some stage. Zero fraction fields on the selected and the unselected tap show whether the divide-by-zero guard is applied to the right tap only. Maximum and minimum divide fields together with garbage in unused bits probe the field extraction. A second start issued mid-computation with a different configuration separates a correctly ignored start from one that restarts or re-samples. Every clock-select code, including the unsupported ones, is swept after each run.

// File: rtl/clkfreq_pkg.sv
package clkfreq_pkg;

  typedef enum logic [1:0] {
    ST_IDLE   = 2'd0,
    ST_LAUNCH = 2'd1,
    ST_WAIT   = 2'd2
  } seq_state_e;

  typedef enum logic [2:0] {
    OP_PFD0 = 3'd0,
    OP_PFD2 = 3'd1,
    OP_AHB  = 3'd2,
    OP_IPG  = 3'd3,
    OP_PER  = 3'd4
  } op_e;

  localparam logic [2:0] CSEL_NONE  = 3'd0;
  localparam logic [2:0] CSEL_IPG   = 3'd1;
  localparam logic [2:0] CSEL_PERHI = 3'd2;
  localparam logic [2:0] CSEL_SLOW  = 3'd3;

  localparam logic [1:0] ROOT_PLL       = 2'd0;
  localparam logic [1:0] ROOT_PFD2      = 2'd1;
  localparam logic [1:0] ROOT_PFD0      = 2'd2;
  localparam logic [1:0] ROOT_PFD2_HALF = 2'd3;

endpackage

// File: rtl/clkfreq_divider.sv
module clkfreq_divider #(
  parameter int unsigned W = 64
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         start_i,
  input  logic [W-1:0] num_i,
  input  logic [W-1:0] den_i,
  output logic         busy_o,
  output logic         done_o,
  output logic [W-1:0] quot_o
);

  localparam int unsigned CW = $clog2(W + 1);

  logic [W-1:0]  rem_q, rem_d;
  logic [W-1:0]  acc_q, acc_d;
  logic [W-1:0]  den_q, den_d;
  logic [CW-1:0] cnt_q, cnt_d;
  logic          busy_q, busy_d;
  logic          done_q, done_d;
  logic          dz_q, dz_d;
  logic          load_en, step_en;
  logic [W:0]    trial;
  logic          ge;

  always_comb begin
    load_en = start_i && !busy_q;
    step_en = busy_q;
    trial   = {rem_q, acc_q[W-1]};
    ge      = (trial >= {1'b0, den_q});

    rem_d  = rem_q;
    acc_d  = acc_q;
    den_d  = den_q;
    cnt_d  = cnt_q;
    busy_d = busy_q;
    dz_d   = dz_q;
    done_d = 1'b0;

    if (load_en) begin
      rem_d  = '0;
      acc_d  = num_i;
      den_d  = den_i;
      cnt_d  = CW'(W);
      busy_d = 1'b1;
      dz_d   = (den_i == '0);
    end else if (step_en) begin
      rem_d = ge ? W'(trial - {1'b0, den_q}) : trial[W-1:0];
      acc_d = {acc_q[W-2:0], ge};
      cnt_d = cnt_q - CW'(1);
      if (cnt_q == CW'(1)) begin
        busy_d = 1'b0;
        done_d = 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rem_q  <= '0;
      acc_q  <= '0;
      den_q  <= '0;
      cnt_q  <= '0;
      busy_q <= 1'b0;
      done_q <= 1'b0;
      dz_q   <= 1'b0;
    end else begin
      if (load_en || step_en) begin
        rem_q <= rem_d;
        acc_q <= acc_d;
        cnt_q <= cnt_d;
      end
      if (load_en) begin
        den_q <= den_d;
        dz_q  <= dz_d;
      end
      busy_q <= busy_d;
      done_q <= done_d;
    end
  end

  assign busy_o = busy_q;
  assign done_o = done_q;
  assign quot_o = dz_q ? '0 : acc_q;

  // R5
  cnt_live_chk: assert property (@(posedge clk) disable iff (!rst_n)
    busy_q |-> (cnt_q != '0));

endmodule

// File: rtl/clkfreq_seq.sv
module clkfreq_seq
  import clkfreq_pkg::*;
#(
  parameter int unsigned      W         = 64,
  parameter int unsigned      CFG_W     = 32,
  parameter longint unsigned  REF_HZ    = 64'd24000000,
  parameter int unsigned      MUL_HI    = 22,
  parameter int unsigned      MUL_LO    = 20,
  parameter int unsigned      PFD_MUL   = 18,
  parameter int unsigned      DSEL_BIT  = 0,
  parameter int unsigned      FR_W      = 6,
  parameter int unsigned      FR0_LSB   = 0,
  parameter int unsigned      FR2_LSB   = 16,
  parameter int unsigned      RSEL_LSB  = 18,
  parameter int unsigned      AHB_W     = 3,
  parameter int unsigned      AHB_LSB   = 10,
  parameter int unsigned      IPG_W     = 2,
  parameter int unsigned      IPG_LSB   = 8,
  parameter int unsigned      PER_W     = 6,
  parameter int unsigned      PER_LSB   = 0
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start_i,
  input  logic [CFG_W-1:0] pll_cfg_i,
  input  logic [CFG_W-1:0] frac_cfg_i,
  input  logic [CFG_W-1:0] bus_div_cfg_i,
  input  logic [CFG_W-1:0] root_cfg_i,
  input  logic [CFG_W-1:0] per_cfg_i,
  output logic             div_start_o,
  output logic [W-1:0]     div_num_o,
  output logic [W-1:0]     div_den_o,
  input  logic             div_done_i,
  input  logic [W-1:0]     div_quot_i,
  output logic             busy_o,
  output logic             valid_o,
  output logic [W-1:0]     pll_hz_o,
  output logic [W-1:0]     pfd0_hz_o,
  output logic [W-1:0]     pfd2_hz_o,
  output logic [W-1:0]     root_hz_o,
  output logic [W-1:0]     ahb_hz_o,
  output logic [W-1:0]     ipg_hz_o,
  output logic [W-1:0]     per_hz_o
);

  localparam logic [W-1:0] PLL_HI_HZ = W'(REF_HZ * MUL_HI);
  localparam logic [W-1:0] PLL_LO_HZ = W'(REF_HZ * MUL_LO);
  localparam logic [W-1:0] PFD_MUL_W = W'(PFD_MUL);

  seq_state_e       state_q, state_d;
  op_e              op_q, op_d;
  logic             valid_q, valid_d;
  logic [FR_W-1:0]  frac0_q, frac0_d, frac2_q, frac2_d;
  logic [1:0]       rsel_q, rsel_d;
  logic [AHB_W-1:0] ahb_pd_q, ahb_pd_d;
  logic [IPG_W-1:0] ipg_pd_q, ipg_pd_d;
  logic [PER_W-1:0] per_pd_q, per_pd_d;
  logic [W-1:0]     pll_q, pll_d, pfd0_q, pfd0_d, pfd2_q, pfd2_d;
  logic [W-1:0]     ahb_q, ahb_d, ipg_q, ipg_d, per_q, per_d;
  logic [W-1:0]     root_w;
  logic             accept_en, store_en;
  logic             unused_cfg_bits;

  assign unused_cfg_bits = ^{pll_cfg_i, frac_cfg_i, bus_div_cfg_i, root_cfg_i, per_cfg_i};

  always_comb begin
    case (rsel_q)
      ROOT_PLL:  root_w = pll_q;
      ROOT_PFD2: root_w = pfd2_q;
      ROOT_PFD0: root_w = pfd0_q;
      default:   root_w = pfd2_q >> 1;
    endcase
  end

  always_comb begin
    div_num_o = '0;
    div_den_o = '0;
    case (op_q)
      OP_PFD0: begin
        div_num_o = pll_q * PFD_MUL_W;
        div_den_o = W'(frac0_q);
      end
      OP_PFD2: begin
        div_num_o = pll_q * PFD_MUL_W;
        div_den_o = W'(frac2_q);
      end
      OP_AHB: begin
        div_num_o = root_w;
        div_den_o = W'(ahb_pd_q) + W'(1);
      end
      OP_IPG: begin
        div_num_o = ahb_q;
        div_den_o = W'(ipg_pd_q) + W'(1);
      end
      default: begin
        div_num_o = ipg_q;
        div_den_o = W'(per_pd_q) + W'(1);
      end
    endcase
  end

  always_comb begin
    accept_en = start_i && (state_q == ST_IDLE);
    store_en  = div_done_i && (state_q == ST_WAIT);

    state_d  = state_q;
    op_d     = op_q;
    valid_d  = valid_q;
    frac0_d  = frac0_q;
    frac2_d  = frac2_q;
    rsel_d   = rsel_q;
    ahb_pd_d = ahb_pd_q;
    ipg_pd_d = ipg_pd_q;
    per_pd_d = per_pd_q;
    pll_d    = pll_q;
    pfd0_d   = pfd0_q;
    pfd2_d   = pfd2_q;
    ahb_d    = ahb_q;
    ipg_d    = ipg_q;
    per_d    = per_q;

    case (state_q)
      ST_IDLE: begin
        if (accept_en) begin
          frac0_d  = frac_cfg_i[FR0_LSB +: FR_W];
          frac2_d  = frac_cfg_i[FR2_LSB +: FR_W];
          rsel_d   = root_cfg_i[RSEL_LSB +: 2];
          ahb_pd_d = bus_div_cfg_i[AHB_LSB +: AHB_W];
          ipg_pd_d = bus_div_cfg_i[IPG_LSB +: IPG_W];
          per_pd_d = per_cfg_i[PER_LSB +: PER_W];
          pll_d    = pll_cfg_i[DSEL_BIT] ? PLL_HI_HZ : PLL_LO_HZ;
          pfd0_d   = '0;
          pfd2_d   = '0;
          ahb_d    = '0;
          ipg_d    = '0;
          per_d    = '0;
          valid_d  = 1'b0;
          op_d     = OP_PFD0;
          state_d  = ST_LAUNCH;
        end
      end
      ST_LAUNCH: state_d = ST_WAIT;
      default: begin
        if (store_en) begin
          case (op_q)
            OP_PFD0: pfd0_d = div_quot_i;
            OP_PFD2: pfd2_d = div_quot_i;
            OP_AHB:  ahb_d  = div_quot_i;
            OP_IPG:  ipg_d  = div_quot_i;
            default: per_d  = div_quot_i;
          endcase
          if (op_q == OP_PER) begin
            valid_d = 1'b1;
            state_d = ST_IDLE;
          end else begin
            op_d    = op_e'(op_q + 3'd1);
            state_d = ST_LAUNCH;
          end
        end
      end
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q  <= ST_IDLE;
      op_q     <= OP_PFD0;
      valid_q  <= 1'b0;
      frac0_q  <= '0;
      frac2_q  <= '0;
      rsel_q   <= '0;
      ahb_pd_q <= '0;
      ipg_pd_q <= '0;
      per_pd_q <= '0;
      pll_q    <= '0;
      pfd0_q   <= '0;
      pfd2_q   <= '0;
      ahb_q    <= '0;
      ipg_q    <= '0;
      per_q    <= '0;
    end else begin
      state_q <= state_d;
      op_q    <= op_d;
      valid_q <= valid_d;
      if (accept_en) begin
        frac0_q  <= frac0_d;
        frac2_q  <= frac2_d;
        rsel_q   <= rsel_d;
        ahb_pd_q <= ahb_pd_d;
        ipg_pd_q <= ipg_pd_d;
        per_pd_q <= per_pd_d;
        pll_q    <= pll_d;
      end
      if (accept_en || store_en) begin
        pfd0_q <= pfd0_d;
        pfd2_q <= pfd2_d;
        ahb_q  <= ahb_d;
        ipg_q  <= ipg_d;
        per_q  <= per_d;
      end
    end
  end

  assign div_start_o = (state_q == ST_LAUNCH);
  assign busy_o      = (state_q != ST_IDLE);
  assign valid_o     = valid_q;
  assign pll_hz_o    = pll_q;
  assign pfd0_hz_o   = pfd0_q;
  assign pfd2_hz_o   = pfd2_q;
  assign root_hz_o   = root_w;
  assign ahb_hz_o    = ahb_q;
  assign ipg_hz_o    = ipg_q;
  assign per_hz_o    = per_q;

  logic [2*W-1:0] chk_prod, chk_num, chk_den;
  assign chk_prod = {{W{1'b0}}, div_quot_i} * {{W{1'b0}}, div_den_o};
  assign chk_num  = {{W{1'b0}}, div_num_o};
  assign chk_den  = {{W{1'b0}}, div_den_o};

  // R5
  div_exact_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (div_done_i && div_den_o != '0) |->
      (chk_prod <= chk_num) && ((chk_num - chk_prod) < chk_den));

  // R5
  chain_order_chk: assert property (@(posedge clk) disable iff (!rst_n)
    valid_q |-> (per_q <= ipg_q) && (ipg_q <= ahb_q) && (ahb_q <= root_w));

  // R3
  frac_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (valid_q && frac0_q == '0) |-> (pfd0_q == '0));

  // R7
  valid_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (valid_q && !start_i) |=> valid_q);

  // R8
  cfg_freeze_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q != ST_IDLE) |=> ($stable(frac0_q) && $stable(frac2_q) && $stable(rsel_q)
                              && $stable(ahb_pd_q) && $stable(pll_q)));

endmodule

// File: rtl/clkfreq_select.sv
module clkfreq_select
  import clkfreq_pkg::*;
#(
  parameter int unsigned     W       = 64,
  parameter longint unsigned SLOW_HZ = 64'd32768
) (
  input  logic         valid_i,
  input  logic [2:0]   sel_i,
  input  logic [W-1:0] ipg_i,
  input  logic [W-1:0] per_i,
  output logic [W-1:0] sel_hz_o
);

  always_comb begin
    sel_hz_o = '0;
    if (valid_i) begin
      case (sel_i)
        CSEL_IPG:   sel_hz_o = ipg_i;
        CSEL_PERHI: sel_hz_o = per_i;
        CSEL_SLOW:  sel_hz_o = W'(SLOW_HZ);
        default:    sel_hz_o = '0;
      endcase
    end
  end

endmodule

// File: rtl/clk_freq_calc.sv
module clk_freq_calc
  import clkfreq_pkg::*;
#(
  parameter int unsigned     W        = 64,
  parameter int unsigned     CFG_W    = 32,
  parameter longint unsigned REF_HZ   = 64'd24000000,
  parameter longint unsigned SLOW_HZ  = 64'd32768,
  parameter int unsigned     MUL_HI   = 22,
  parameter int unsigned     MUL_LO   = 20,
  parameter int unsigned     PFD_MUL  = 18,
  parameter int unsigned     DSEL_BIT = 0,
  parameter int unsigned     FR_W     = 6,
  parameter int unsigned     FR0_LSB  = 0,
  parameter int unsigned     FR2_LSB  = 16,
  parameter int unsigned     RSEL_LSB = 18,
  parameter int unsigned     AHB_W    = 3,
  parameter int unsigned     AHB_LSB  = 10,
  parameter int unsigned     IPG_W    = 2,
  parameter int unsigned     IPG_LSB  = 8,
  parameter int unsigned     PER_W    = 6,
  parameter int unsigned     PER_LSB  = 0
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start_i,
  input  logic [CFG_W-1:0] pll_cfg_i,
  input  logic [CFG_W-1:0] frac_cfg_i,
  input  logic [CFG_W-1:0] bus_div_cfg_i,
  input  logic [CFG_W-1:0] root_cfg_i,
  input  logic [CFG_W-1:0] per_cfg_i,
  input  logic [2:0]       clk_sel_i,
  output logic             busy_o,
  output logic             valid_o,
  output logic [W-1:0]     pll_hz_o,
  output logic [W-1:0]     pfd0_hz_o,
  output logic [W-1:0]     pfd2_hz_o,
  output logic [W-1:0]     root_hz_o,
  output logic [W-1:0]     ahb_hz_o,
  output logic [W-1:0]     ipg_hz_o,
  output logic [W-1:0]     per_hz_o,
  output logic [W-1:0]     sel_hz_o
);

  logic [1:0]   rst_sync_q;
  logic         rst_int_n;
  logic         div_start, div_done, div_busy;
  logic [W-1:0] div_num, div_den, div_quot;
  logic         unused_div_busy;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= 2'b00;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_int_n       = rst_sync_q[1];
  assign unused_div_busy = div_busy;

  clkfreq_seq #(
    .W(W), .CFG_W(CFG_W), .REF_HZ(REF_HZ), .MUL_HI(MUL_HI), .MUL_LO(MUL_LO),
    .PFD_MUL(PFD_MUL), .DSEL_BIT(DSEL_BIT), .FR_W(FR_W), .FR0_LSB(FR0_LSB),
    .FR2_LSB(FR2_LSB), .RSEL_LSB(RSEL_LSB), .AHB_W(AHB_W), .AHB_LSB(AHB_LSB),
    .IPG_W(IPG_W), .IPG_LSB(IPG_LSB), .PER_W(PER_W), .PER_LSB(PER_LSB)
  ) u_seq (
    .clk          (clk),
    .rst_n        (rst_int_n),
    .start_i      (start_i),
    .pll_cfg_i    (pll_cfg_i),
    .frac_cfg_i   (frac_cfg_i),
    .bus_div_cfg_i(bus_div_cfg_i),
    .root_cfg_i   (root_cfg_i),
    .per_cfg_i    (per_cfg_i),
    .div_start_o  (div_start),
    .div_num_o    (div_num),
    .div_den_o    (div_den),
    .div_done_i   (div_done),
    .div_quot_i   (div_quot),
    .busy_o       (busy_o),
    .valid_o      (valid_o),
    .pll_hz_o     (pll_hz_o),
    .pfd0_hz_o    (pfd0_hz_o),
    .pfd2_hz_o    (pfd2_hz_o),
    .root_hz_o    (root_hz_o),
    .ahb_hz_o     (ahb_hz_o),
    .ipg_hz_o     (ipg_hz_o),
    .per_hz_o     (per_hz_o)
  );

  clkfreq_divider #(.W(W)) u_div (
    .clk    (clk),
    .rst_n  (rst_int_n),
    .start_i(div_start),
    .num_i  (div_num),
    .den_i  (div_den),
    .busy_o (div_busy),
    .done_o (div_done),
    .quot_o (div_quot)
  );

  clkfreq_select #(.W(W), .SLOW_HZ(SLOW_HZ)) u_sel (
    .valid_i (valid_o),
    .sel_i   (clk_sel_i),
    .ipg_i   (ipg_hz_o),
    .per_i   (per_hz_o),
    .sel_hz_o(sel_hz_o)
  );

  // R6
  perhi_le_ipg_chk: assert property (@(posedge clk) disable iff (!rst_int_n)
    (valid_o && clk_sel_i == CSEL_PERHI) |-> (sel_hz_o <= ipg_hz_o));

  // R9
  idle_after_reset_chk: assert property (@(posedge clk) disable iff (!rst_int_n)
    (!busy_o && !valid_o && !start_i) |=> !valid_o);

endmodule

// File: tb/tb_clk_freq_calc.sv
module tb_clk_freq_calc;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        start;
  logic [31:0] pll_cfg, frac_cfg, bus_cfg, root_cfg, per_cfg;
  logic [2:0]  clk_sel;
  logic        busy, valid;
  logic [63:0] pll_hz, pfd0_hz, pfd2_hz, root_hz, ahb_hz, ipg_hz, per_hz, sel_hz;

  int checks = 0;
  int fails  = 0;
  bit cmp_en = 1'b0;
  bit done_flag = 1'b0;

  logic [63:0] e_pll, e_pfd0, e_pfd2, e_root, e_ahb, e_ipg, e_per;

  always #4 clk = ~clk;

  clk_freq_calc dut (
    .clk(clk), .rst_n(rst_n), .start_i(start),
    .pll_cfg_i(pll_cfg), .frac_cfg_i(frac_cfg), .bus_div_cfg_i(bus_cfg),
    .root_cfg_i(root_cfg), .per_cfg_i(per_cfg), .clk_sel_i(clk_sel),
    .busy_o(busy), .valid_o(valid),
    .pll_hz_o(pll_hz), .pfd0_hz_o(pfd0_hz), .pfd2_hz_o(pfd2_hz), .root_hz_o(root_hz),
    .ahb_hz_o(ahb_hz), .ipg_hz_o(ipg_hz), .per_hz_o(per_hz), .sel_hz_o(sel_hz)
  );

  task automatic chk(input string req, input string what, input logic [63:0] act,
                     input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  task automatic model(input logic [31:0] p, input logic [31:0] f, input logic [31:0] b,
                       input logic [31:0] r, input logic [31:0] q);
    logic [63:0] f0, f2;
    e_pll  = p[0] ? 64'd528000000 : 64'd480000000;
    f0     = 64'(f[5:0]);
    f2     = 64'(f[21:16]);
    e_pfd0 = (f0 == 0) ? 64'd0 : (e_pll * 64'd18) / f0;
    e_pfd2 = (f2 == 0) ? 64'd0 : (e_pll * 64'd18) / f2;
    case (r[19:18])
      2'd0: e_root = e_pll;
      2'd1: e_root = e_pfd2;
      2'd2: e_root = e_pfd0;
      default: e_root = e_pfd2 / 64'd2;
    endcase
    e_ahb = e_root / (64'(b[12:10]) + 64'd1);
    e_ipg = e_ahb  / (64'(b[9:8])   + 64'd1);
    e_per = e_ipg  / (64'(q[5:0])   + 64'd1);
  endtask

  // Reference comparison on every clock while results are expected to be held
  always @(negedge clk) begin
    if (cmp_en) begin
      chk("R7", "valid held", 64'(valid), 64'd1);
      chk("R1", "pll", pll_hz, e_pll);
      chk("R2", "tap0", pfd0_hz, e_pfd0);
      chk("R2", "tap2", pfd2_hz, e_pfd2);
      chk("R4", "root", root_hz, e_root);
      chk("R5", "ahb", ahb_hz, e_ahb);
      chk("R5", "ipg", ipg_hz, e_ipg);
      chk("R5", "per", per_hz, e_per);
    end
  end

  task automatic drive(input logic [31:0] p, input logic [31:0] f, input logic [31:0] b,
                       input logic [31:0] r, input logic [31:0] q);
    pll_cfg = p; frac_cfg = f; bus_cfg = b; root_cfg = r; per_cfg = q;
  endtask

  task automatic pulse_start();
    cmp_en = 1'b0;
    start  = 1'b1;
    @(negedge clk);
    start  = 1'b0;
    chk("R7", "valid low after start", 64'(valid), 64'd0);
    chk("R6", "select zero while not valid", sel_hz, 64'd0);
  endtask

  task automatic wait_valid(input int first_n);
    int n = first_n;
    while (!valid && n < 2000) begin
      @(negedge clk);
      n++;
    end
    chk("R7", "latency within 331", 64'(n <= 331), 64'd1);
    cmp_en = 1'b1;
  endtask

  task automatic sweep_sel();
    for (int s = 0; s < 8; s++) begin
      clk_sel = 3'(s);
      #1;
      case (s)
        1: chk("R6", "sel ipg", sel_hz, e_ipg);
        2: chk("R6", "sel perhi", sel_hz, e_per);
        3: chk("R6", "sel slow", sel_hz, 64'd32768);
        default: chk("R6", "sel none/unsupported", sel_hz, 64'd0);
      endcase
      @(negedge clk);
    end
  endtask

  task automatic run(input logic [31:0] p, input logic [31:0] f, input logic [31:0] b,
                     input logic [31:0] r, input logic [31:0] q);
    drive(p, f, b, r, q);
    pulse_start();
    model(p, f, b, r, q);
    chk("R7", "busy after start", 64'(busy), 64'd1);
    wait_valid(1);
    sweep_sel();
  endtask

  task automatic finish_up();
    if (!done_flag) begin
      done_flag = 1'b1;
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  endtask

  initial begin
    #(8 * 200000);
    checks++;
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_up();
  end

  initial begin
    rst_n = 1'b0;
    start = 1'b0;
    clk_sel = 3'd1;
    drive(32'h1, 32'h0018_001B, 32'h0000_0D00, 32'h0004_0000, 32'h0);
    repeat (3) @(negedge clk);
    // R9: reset state
    chk("R9", "valid", 64'(valid), 64'd0);
    chk("R9", "busy", 64'(busy), 64'd0);
    chk("R9", "pll", pll_hz, 64'd0);
    chk("R9", "per", per_hz, 64'd0);
    chk("R9", "sel", sel_hz, 64'd0);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    chk("R9", "valid after release", 64'(valid), 64'd0);

    // R1 R2 R4 R5: high multiplier, root from tap 2
    run(32'h1, 32'h0018_001B, 32'h0000_0D00, 32'h0004_0000, 32'h0);
    // R1: low multiplier with garbage in other bits, root from tap 0, max per divide
    run(32'hFFFF_FFFE, 32'h001D_0023, 32'h0000_0300, 32'h0008_0000, 32'hFFFF_FFFF);
    // R4: halved tap 2, max AHB and IPG divides
    run(32'h1, 32'h0011_0010, 32'h0000_1F00, 32'h000C_0000, 32'h5);
    // R3: zero fraction on selected tap 2
    run(32'h1, 32'h0000_000C, 32'h0, 32'h0004_0000, 32'h0);
    // R3: zero fraction on selected tap 0
    run(32'h0, 32'h0020_0000, 32'h0, 32'h0008_0000, 32'h1);
    // R4: root straight from PLL
    run(32'h0, 32'h0020_0020, 32'h0000_0400, 32'h0, 32'h2);

    // R8: a second start mid-computation with other settings is ignored
    drive(32'h1, 32'h0018_001B, 32'h0000_0D00, 32'h0004_0000, 32'h0);
    pulse_start();
    model(32'h1, 32'h0018_001B, 32'h0000_0D00, 32'h0004_0000, 32'h0);
    repeat (40) @(negedge clk);
    drive(32'h0, 32'h0005_0007, 32'h0000_1F00, 32'h000C_0000, 32'h3F);
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    chk("R8", "busy kept after ignored start", 64'(busy), 64'd1);
    wait_valid(42);
    repeat (5) @(negedge clk);
    chk("R8", "ipg from first settings", ipg_hz, e_ipg);
    sweep_sel();

    cmp_en = 1'b0;
    @(negedge clk);
    finish_up();
  end

endmodule